// File: doc/BRIEF.md
# Pixel Sampling Clock Sequencer

This block produces the three per-pixel clocks that an image-sensor analog front end needs: a reset-level sample clock, a data-level sample clock and a converter clock. It runs from a fast system clock. Every pulse width and every gap between pulses is a system-clock cycle count taken from configuration inputs, so one netlist can serve any pixel rate. In correlated double sampling mode the reset-level clock pulses first and the data-level clock follows it in the same pixel. In sample-and-hold mode only the data-level clock pulses and the reset-level clock stays low.

The converter delivers a word three converter-clock periods after the pixel it belongs to was sampled. The sequencer follows this latency with a three-stage delay line that moves one step on each converter-clock rising edge, and emits a one-cycle strobe and a pixel tag that name the pixel whose word is now on the converter output. The tag counts pixels within a line and wraps at a programmed line length. The strobe has no ready input: the converter cannot be stalled, so the receiver must take each word in the cycle it is flagged. A combinational check output flags any count below the timing minimum for the system-clock period, and a run cannot start while it is raised.

Top module: `pix_clk_seq`

## Requirements
- R1: In double-sampling mode, with pixel cycle index t counted from 0 in the first cycle after the start, `cds_rst_ck` is high for t < W (W = `cfg_rst_w`) and `cds_dat_ck` is high for W+G <= t < W+G+D (G = `cfg_gap_rd`, D = `cfg_dat_w`); each output lags its pixel cycle by one register.
- R2: In sample-and-hold mode (`mode_cds` = 0), `cds_rst_ck` stays low while `cds_dat_ck` keeps the same offsets as in R1.
- R3: `conv_ck` is high for E <= t < E+H, with E = W+G+D+`cfg_gap_dc` and H = `cfg_conv_hi`; a pixel lasts `cfg_period` cycles.
- R4: `cfg_bad` is 1 when, with a 10 ns system clock, W or D is below 4, G below 2, the data-to-converter gap below 8, H or `cfg_period`-H below 17, `cfg_period` below 34, E+H exceeds `cfg_period`, or `cfg_line_len` is 0; values exactly at these limits give 0.
- R5: From idle, `run` high with `cfg_bad` low starts a pixel at the next cycle; `run` is sampled only in the last cycle of a pixel, and when low there the block returns to idle, where all three clocks are low and `busy` is 0.
- R6: While `cfg_bad` is 1, `run` does not start the sequencer.
- R7: `word_valid` pulses for one cycle together with a rising edge of `conv_ck`, only when three converter edges have occurred since the start; the delay line is cleared at each start.
- R8: `word_tag` carries the pixel index of the pixel whose converter edge came three edges earlier; the index starts at 0 on each start and wraps from `cfg_line_len`-1 to 0.
- R9: After reset all clocks, `busy` and `word_valid` are 0.
- R10: The mode is captured at the start; changes of `mode_cds` during a run have no effect until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Request to keep producing pixels |
| mode_cds | input | 1 | 1 selects double sampling, 0 sample-and-hold |
| cfg_rst_w | input | CW | Reset-level pulse width in cycles |
| cfg_gap_rd | input | CW | Cycles from reset-level fall to data-level rise |
| cfg_dat_w | input | CW | Data-level pulse width in cycles |
| cfg_gap_dc | input | CW | Cycles from data-level fall to converter rise |
| cfg_conv_hi | input | CW | Converter clock high cycles |
| cfg_period | input | CW | Pixel period in cycles |
| cfg_line_len | input | LW | Pixels per line for the tag counter |
| busy | output | 1 | Sequencer is producing pixels |
| cfg_bad | output | 1 | A programmed count violates a timing minimum |
| cds_rst_ck | output | 1 | Reset-level sample clock |
| cds_dat_ck | output | 1 | Data-level sample clock |
| conv_ck | output | 1 | Converter clock |
| word_valid | output | 1 | Converter word for a tagged pixel is now present |
| word_tag | output | LW | Pixel index belonging to the flagged word |

## Verification
The bench programs every count at exactly its minimum and then one cycle below, so a checker with an off-by-one compare would either reject a legal setting or let an illegal one start. It drops `run` in the middle of a pixel, where a design that stops at once would cut a converter high phase short, and restarts after a stop, where a delay line that is not cleared would flag a stale tag from the previous run. It flips the mode during a run, which a design without a captured mode would show as a reset-level pulse appearing mid-run, and uses a short line so the tag wrap and a line length of one are both crossed.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  // Timing minimums of the front end, in nanoseconds.
  localparam int T_PULSE_NS = 40;
  localparam int T_SEP_NS   = 20;
  localparam int T_CONV_NS  = 80;
  localparam int T_HALF_NS  = 166;
  localparam int T_PIXEL_NS = 332;

  // Smallest whole number of system cycles covering a time span.
  function automatic int ns_to_cyc(input int ns, input int per_ns);
    return (ns + per_ns - 1) / per_ns;
  endfunction
endpackage

// File: rtl/pcs_cfg_check.sv
module pcs_cfg_check #(
  parameter int CW     = 8,
  parameter int LW     = 8,
  parameter int SYS_NS = 10
) (
  input  logic [CW-1:0] w_rst,
  input  logic [CW-1:0] g_rd,
  input  logic [CW-1:0] w_dat,
  input  logic [CW-1:0] g_dc,
  input  logic [CW-1:0] w_conv,
  input  logic [CW-1:0] period,
  input  logic [LW-1:0] line_len,
  output logic          bad
);
  import pcs_pkg::*;
  localparam int SW = CW + 3;
  localparam logic [SW-1:0] MIN_PULSE = SW'(ns_to_cyc(T_PULSE_NS, SYS_NS));
  localparam logic [SW-1:0] MIN_SEP   = SW'(ns_to_cyc(T_SEP_NS, SYS_NS));
  localparam logic [SW-1:0] MIN_CONV  = SW'(ns_to_cyc(T_CONV_NS, SYS_NS));
  localparam logic [SW-1:0] MIN_HALF  = SW'(ns_to_cyc(T_HALF_NS, SYS_NS));
  localparam logic [SW-1:0] MIN_PIX   = SW'(ns_to_cyc(T_PIXEL_NS, SYS_NS));

  logic [SW-1:0] per_x, conv_at, conv_end;

  always_comb begin
    per_x    = SW'(period);
    conv_at  = SW'(w_rst) + SW'(g_rd) + SW'(w_dat) + SW'(g_dc);
    conv_end = conv_at + SW'(w_conv);
    bad = 1'b0;
    if (SW'(w_rst) < MIN_PULSE)  bad = 1'b1;
    if (SW'(w_dat) < MIN_PULSE)  bad = 1'b1;
    if (SW'(g_rd) < MIN_SEP)     bad = 1'b1;
    if (SW'(g_dc) < MIN_CONV)    bad = 1'b1;
    if (SW'(w_conv) < MIN_HALF)  bad = 1'b1;
    if (per_x < MIN_PIX)         bad = 1'b1;
    if (conv_end > per_x)        bad = 1'b1;
    else if (per_x - SW'(w_conv) < MIN_HALF) bad = 1'b1;
    if (line_len == '0)          bad = 1'b1;
  end
endmodule

// File: rtl/pcs_timer.sv
module pcs_timer #(
  parameter int CW = 8,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          mode_in,
  input  logic          bad,
  input  logic [CW-1:0] period,
  input  logic [LW-1:0] line_len,
  output logic          active,
  output logic          mode_q,
  output logic          start,
  output logic [CW-1:0] t,
  output logic [LW-1:0] pix
);
  logic last_cyc;

  assign start    = !active && run && !bad;
  assign last_cyc = (t == period - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      mode_q <= 1'b0;
      t      <= '0;
      pix    <= '0;
    end else if (!active) begin
      if (start) begin
        active <= 1'b1;
        mode_q <= mode_in;
        t      <= '0;
        pix    <= '0;
      end
    end else if (last_cyc) begin
      if (run) begin
        t   <= '0;
        pix <= (pix == line_len - 1'b1) ? '0 : pix + 1'b1;
      end else begin
        active <= 1'b0;
      end
    end else begin
      t <= t + 1'b1;
    end
  end
endmodule

// File: rtl/pcs_lat_line.sv
module pcs_lat_line #(
  parameter int DEPTH = 3,
  parameter int LW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  logic [LW-1:0] tag_in,
  output logic          out_valid,
  output logic [LW-1:0] out_tag
);
  logic [DEPTH-1:0] st_v;
  logic [LW-1:0]    st_tag [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_v      <= '0;
      out_valid <= 1'b0;
      out_tag   <= '0;
      for (int i = 0; i < DEPTH; i++) st_tag[i] <= '0;
    end else begin
      out_valid <= push && st_v[DEPTH-1];
      if (push) out_tag <= st_tag[DEPTH-1];
      if (clear) begin
        st_v <= '0;
      end else if (push) begin
        st_v      <= {st_v[DEPTH-2:0], 1'b1};
        st_tag[0] <= tag_in;
        for (int i = 1; i < DEPTH; i++) st_tag[i] <= st_tag[i-1];
      end
    end
  end
endmodule

// File: rtl/pix_clk_seq.sv
module pix_clk_seq #(
  parameter int CW     = 8,
  parameter int LW     = 8,
  parameter int SYS_NS = 10,
  parameter int LAT    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          mode_cds,
  input  logic [CW-1:0] cfg_rst_w,
  input  logic [CW-1:0] cfg_gap_rd,
  input  logic [CW-1:0] cfg_dat_w,
  input  logic [CW-1:0] cfg_gap_dc,
  input  logic [CW-1:0] cfg_conv_hi,
  input  logic [CW-1:0] cfg_period,
  input  logic [LW-1:0] cfg_line_len,
  output logic          busy,
  output logic          cfg_bad,
  output logic          cds_rst_ck,
  output logic          cds_dat_ck,
  output logic          conv_ck,
  output logic          word_valid,
  output logic [LW-1:0] word_tag
);
  localparam int SW = CW + 3;

  logic          mode_q, start;
  logic [CW-1:0] t;
  logic [LW-1:0] pix;
  logic [SW-1:0] tx, dat_on, dat_off, cv_on, cv_off;
  logic          rst_d, dat_d, cv_d, cv_rise;

  pcs_cfg_check #(.CW(CW), .LW(LW), .SYS_NS(SYS_NS)) u_chk (
    .w_rst(cfg_rst_w), .g_rd(cfg_gap_rd), .w_dat(cfg_dat_w), .g_dc(cfg_gap_dc),
    .w_conv(cfg_conv_hi), .period(cfg_period), .line_len(cfg_line_len), .bad(cfg_bad)
  );

  pcs_timer #(.CW(CW), .LW(LW)) u_tim (
    .clk(clk), .rst_n(rst_n), .run(run), .mode_in(mode_cds), .bad(cfg_bad),
    .period(cfg_period), .line_len(cfg_line_len), .active(busy), .mode_q(mode_q),
    .start(start), .t(t), .pix(pix)
  );

  // Edge positions within the pixel, in cycles from its first cycle.
  always_comb begin
    tx      = SW'(t);
    dat_on  = SW'(cfg_rst_w) + SW'(cfg_gap_rd);
    dat_off = dat_on + SW'(cfg_dat_w);
    cv_on   = dat_off + SW'(cfg_gap_dc);
    cv_off  = cv_on + SW'(cfg_conv_hi);
    rst_d   = busy && mode_q && (tx < SW'(cfg_rst_w));
    dat_d   = busy && (tx >= dat_on) && (tx < dat_off);
    cv_d    = busy && (tx >= cv_on) && (tx < cv_off);
    cv_rise = cv_d && !conv_ck;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cds_rst_ck <= 1'b0;
      cds_dat_ck <= 1'b0;
      conv_ck    <= 1'b0;
    end else begin
      cds_rst_ck <= rst_d;
      cds_dat_ck <= dat_d;
      conv_ck    <= cv_d;
    end
  end

  pcs_lat_line #(.DEPTH(LAT), .LW(LW)) u_lat (
    .clk(clk), .rst_n(rst_n), .clear(start), .push(cv_rise), .tag_in(pix),
    .out_valid(word_valid), .out_tag(word_tag)
  );
endmodule

// File: rtl/pcs_sva.sv
module pcs_sva #(
  parameter int CW     = 8,
  parameter int LW     = 8,
  parameter int SYS_NS = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          mode_q,
  input logic          cfg_bad,
  input logic          cds_rst_ck,
  input logic          cds_dat_ck,
  input logic          conv_ck,
  input logic          word_valid,
  input logic [LW-1:0] word_tag,
  input logic [LW-1:0] cfg_line_len
);
  import pcs_pkg::*;
  localparam int MIN_PULSE = ns_to_cyc(T_PULSE_NS, SYS_NS);

  logic [15:0] dat_hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          dat_hi_cnt <= '0;
    else if (cds_dat_ck) dat_hi_cnt <= dat_hi_cnt + 1'b1;
    else                 dat_hi_cnt <= '0;
  end

  p_no_overlap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(cds_rst_ck && cds_dat_ck));
  p_dat_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cds_dat_ck) && !cfg_bad) |-> (dat_hi_cnt >= 16'(MIN_PULSE)));
  p_sh_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mode_q) |=> !cds_rst_ck);
  p_idle_park_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (!cds_rst_ck && !cds_dat_ck && !conv_ck));
  p_no_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cfg_bad) |=> !busy);
  p_valid_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $rose(conv_ck));
  p_tag_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> (word_tag < cfg_line_len));
endmodule

bind pix_clk_seq pcs_sva #(.CW(CW), .LW(LW), .SYS_NS(SYS_NS)) u_sva (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mode_q(mode_q), .cfg_bad(cfg_bad),
  .cds_rst_ck(cds_rst_ck), .cds_dat_ck(cds_dat_ck), .conv_ck(conv_ck),
  .word_valid(word_valid), .word_tag(word_tag), .cfg_line_len(cfg_line_len)
);

// File: tb/pix_clk_seq_tb.sv
module pix_clk_seq_tb;
  localparam int CW = 8;
  localparam int LW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic mode_cds = 1'b1;
  logic [CW-1:0] cfg_rst_w = 8'd4, cfg_gap_rd = 8'd2, cfg_dat_w = 8'd4;
  logic [CW-1:0] cfg_gap_dc = 8'd8, cfg_conv_hi = 8'd17, cfg_period = 8'd40;
  logic [LW-1:0] cfg_line_len = 8'd5;
  logic busy, cfg_bad, cds_rst_ck, cds_dat_ck, conv_ck, word_valid;
  logic [LW-1:0] word_tag;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pix_clk_seq u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .mode_cds(mode_cds),
    .cfg_rst_w(cfg_rst_w), .cfg_gap_rd(cfg_gap_rd), .cfg_dat_w(cfg_dat_w),
    .cfg_gap_dc(cfg_gap_dc), .cfg_conv_hi(cfg_conv_hi), .cfg_period(cfg_period),
    .cfg_line_len(cfg_line_len), .busy(busy), .cfg_bad(cfg_bad),
    .cds_rst_ck(cds_rst_ck), .cds_dat_ck(cds_dat_ck), .conv_ck(conv_ck),
    .word_valid(word_valid), .word_tag(word_tag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model.
  int  m_act, m_t, m_pix, m_mode, x_tag;
  bit  x_rst, x_dat, x_cv, x_dv;
  int  tagq[$];
  int  s2, e2, ae, ah;
  bit  n_rst, n_dat, n_cv;

  function automatic bit exp_bad();
    int per, hi, cend;
    per = cfg_period; hi = cfg_conv_hi;
    cend = cfg_rst_w + cfg_gap_rd + cfg_dat_w + cfg_gap_dc + hi;
    return (cfg_rst_w < 4) || (cfg_dat_w < 4) || (cfg_gap_rd < 2) ||
           (cfg_gap_dc < 8) || (hi < 17) || (per < 34) || (cend > per) ||
           (per - hi < 17) || (cfg_line_len == 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_t = 0; m_pix = 0; m_mode = 0;
      x_rst = 0; x_dat = 0; x_cv = 0; x_dv = 0; x_tag = 0;
      tagq.delete();
    end else begin
      s2 = cfg_rst_w + cfg_gap_rd;
      e2 = s2 + cfg_dat_w;
      ae = e2 + cfg_gap_dc;
      ah = ae + cfg_conv_hi;
      n_rst = (m_act != 0) && (m_mode != 0) && (m_t < cfg_rst_w);
      n_dat = (m_act != 0) && (m_t >= s2) && (m_t < e2);
      n_cv  = (m_act != 0) && (m_t >= ae) && (m_t < ah);
      x_dv = 0;
      if (n_cv && !x_cv) begin
        if (tagq.size() == 3) begin
          x_dv = 1;
          x_tag = tagq.pop_front();
        end
        tagq.push_back(m_pix);
      end
      x_rst = n_rst; x_dat = n_dat; x_cv = n_cv;
      if (m_act == 0) begin
        if (run && !exp_bad()) begin
          m_act = 1; m_t = 0; m_pix = 0; m_mode = mode_cds; tagq.delete();
        end
      end else if (m_t == cfg_period - 1) begin
        if (run) begin
          m_t = 0;
          m_pix = (m_pix == cfg_line_len - 1) ? 0 : m_pix + 1;
        end else m_act = 0;
      end else m_t++;
    end
  end

  // Compare every cycle, 2 ns after the rising edge.
  always begin
    @(posedge clk);
    #2;
    if (rst_n && !finished) begin
      if (m_act != 0 && (mode_cds != m_mode[0]))
        chk(cds_rst_ck == x_rst, "R10 mode held", cds_rst_ck, x_rst);
      else if (m_mode != 0)
        chk(cds_rst_ck == x_rst, "R1 reset-level clock", cds_rst_ck, x_rst);
      else
        chk(cds_rst_ck == x_rst, "R2 reset-level clock in S/H", cds_rst_ck, x_rst);
      chk(cds_dat_ck == x_dat, "R1 data-level clock", cds_dat_ck, x_dat);
      chk(conv_ck == x_cv, "R3 converter clock", conv_ck, x_cv);
      chk(cfg_bad == exp_bad(), "R4 config check", cfg_bad, exp_bad());
      chk(busy == (m_act != 0), "R5 busy", busy, m_act);
      chk(word_valid == x_dv, "R7 word strobe", word_valid, x_dv);
      if (x_dv) chk(int'(word_tag) == x_tag, "R8 word tag", word_tag, x_tag);
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(input int w1, g1, w2, g2, h, per, ll);
    @(negedge clk);
    cfg_rst_w = 8'(w1); cfg_gap_rd = 8'(g1); cfg_dat_w = 8'(w2);
    cfg_gap_dc = 8'(g2); cfg_conv_hi = 8'(h); cfg_period = 8'(per);
    cfg_line_len = 8'(ll);
  endtask

  task automatic stop_and_idle();
    @(negedge clk); run = 1'b0;
    cycles(70);
    chk(busy == 1'b0, "R5 stopped after pixel end", busy, 0);
    chk(!cds_rst_ck && !cds_dat_ck && !conv_ck, "R5 clocks parked low",
        {cds_rst_ck, cds_dat_ck, conv_ck}, 0);
  endtask

  task automatic bad_try(input int w1, g1, w2, g2, h, per, ll);
    set_cfg(w1, g1, w2, g2, h, per, ll);
    @(negedge clk); run = 1'b1;
    cycles(3);
    chk(cfg_bad == 1'b1, "R4 below-minimum flagged", cfg_bad, 1);
    chk(busy == 1'b0, "R6 start refused", busy, 0);
    @(negedge clk); run = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cycles(3);
    chk(!busy && !cds_rst_ck && !cds_dat_ck && !conv_ck && !word_valid,
        "R9 reset state", {busy, cds_rst_ck, cds_dat_ck, conv_ck, word_valid}, 0);
    @(negedge clk); rst_n = 1'b1;
    cycles(2);
    chk(cfg_bad == 1'b0, "R4 limits exactly met", cfg_bad, 0);

    // Double sampling at minimum counts, line of 5.
    @(negedge clk); mode_cds = 1'b1; run = 1'b1;
    cycles(40 * 12 + 17);
    stop_and_idle();

    // Sample-and-hold, wider counts, mode flips mid-run.
    set_cfg(6, 3, 5, 9, 20, 50, 3);
    @(negedge clk); mode_cds = 1'b0; run = 1'b1;
    cycles(50 * 5 + 11);
    @(negedge clk); mode_cds = 1'b1;
    cycles(50 * 4);
    stop_and_idle();

    // Restart in double sampling: tag restarts, stale entries cleared.
    @(negedge clk); run = 1'b1;
    cycles(50 * 2 + 30);
    stop_and_idle();
    @(negedge clk); run = 1'b1;
    cycles(50 * 6);
    stop_and_idle();

    // One-pixel line.
    set_cfg(5, 2, 4, 8, 18, 40, 1);
    @(negedge clk); run = 1'b1;
    cycles(40 * 6);
    stop_and_idle();

    // One below each limit.
    bad_try(3, 2, 4, 8, 17, 40, 5);
    bad_try(4, 1, 4, 8, 17, 40, 5);
    bad_try(4, 2, 3, 8, 17, 40, 5);
    bad_try(4, 2, 4, 7, 17, 40, 5);
    bad_try(4, 2, 4, 8, 16, 40, 5);
    bad_try(4, 2, 4, 8, 17, 33, 5);
    bad_try(4, 2, 4, 8, 17, 34, 5);
    bad_try(4, 2, 4, 8, 30, 46, 5);
    bad_try(4, 2, 4, 8, 17, 40, 0);

    cycles(5);
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule